// File: doc/BRIEF.md
# Two-Band Adaptive Equalizer Control Engine

This block is the digital loop that keeps tuning a four-stage receive linear equalizer while the link runs. The analog front end compares the received signal in two frequency bands and hands the engine a pair of up/down indications per band at every decision strobe. The engine filters these votes: a band moves its 3-bit code by one step only after a programmable number of consecutive agreeing votes. The two codes are presented to every equalizer stage's control DAC. Adaptation never stops. A per-band convergence flag reports whether the code has been dithering around its target, measured as direction reversals of the applied steps over a fixed window of decision strobes. Two 2-bit filter bandwidth selects are held for the front end, and every setting can be read back on a small read port so the fabric can monitor the link.

Each band runs its own vote tracker, a state machine with three states. TRK_IDLE means no run is open. TRK_UP means a run of up votes is being counted. TRK_DN means a run of down votes is being counted. From TRK_IDLE, an up vote enters TRK_UP and a down vote enters TRK_DN, each with a count of one. In TRK_UP or TRK_DN, a vote in the same direction extends the count. A vote in the opposite direction switches to the other run state with a count of one. When the count reaches the threshold, the step fires and the tracker returns to TRK_IDLE. A neutral vote leaves state and count unchanged. A seed load returns the tracker to TRK_IDLE from any state.

The engine can be frozen, or it can be seeded with starting codes at any time.

Top module: `eq_adapt_engine`

## Requirements
- R1: After reset, both codes are 0, both convergence flags are 0, both bandwidth selects are 0, every stage control field is 0 and every read address returns 0.
- R2: A band's vote is decoded as follows. Up=1 with down=0 is an up vote. Down=1 with up=0 is a down vote. Both or neither is neutral; a neutral vote neither counts nor breaks a run. The code steps once, on the strobe that completes a run of N consecutive agreeing votes, and the run then restarts from zero. N comes from `agree_n`, and a value of 0 acts as 1.
- R3: A vote opposite to the current run restarts that band's run at a count of one in the new direction.
- R4: A code moves by at most one per strobe. It saturates at 0 and at 7 and never wraps. A step that would pass a limit leaves the code unchanged.
- R5: The two bands are independent: votes, runs and codes of one band never affect the other.
- R6: While `adapt_en` is 0, decision strobes are ignored. Codes, run counts, the convergence window and the flags all hold, and counting resumes where it stopped when `adapt_en` returns to 1.
- R7: `seed_load` forces both codes to the seed inputs on the next edge. It also clears runs, direction history, the window and both flags. It takes priority over both `adapt_en` and `vote_valid`.
- R8: A reversal is a fired step whose direction differs from the previous fired step of the same band since the last seed load; a step clamped at a limit still counts as fired. Every WIN_LEN (default 16) enabled strobes, each flag is updated to 1 if that band's reversals in the window reached `alt_m`, and to 0 otherwise; `alt_m` = 0 never sets the flag. The flag holds between window ends.
- R9: A pulse on `bw_wr` loads `lpf_bw_wr` into `lpf_bw` and `hpf_bw_wr` into `hpf_bw`. Both selects hold otherwise.
- R10: `rd_data` returns the following, zero-extended. Address 0 gives {lf_conv, lf_code} with the flag in bit 3. Address 1 gives {hf_conv, hf_code}. Address 2 gives {hpf_bw, lpf_bw} with the low-pass select in bits 1:0. Address 3 returns 0.
- R11: Each of the four stage fields `stage_ctrl[6*i +: 6]` carries {hf_code, lf_code}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adapt_en | input | 1 | Adaptation enable; 0 freezes the engine |
| vote_valid | input | 1 | Decision strobe qualifying the four vote inputs |
| lf_up | input | 1 | Low band up indication |
| lf_dn | input | 1 | Low band down indication |
| hf_up | input | 1 | High band up indication |
| hf_dn | input | 1 | High band down indication |
| seed_load | input | 1 | Force codes to the seed values |
| lf_seed | input | 3 | Low band seed code |
| hf_seed | input | 3 | High band seed code |
| agree_n | input | 4 | Consecutive agreeing votes needed per step |
| alt_m | input | 4 | Reversals per window needed for convergence |
| bw_wr | input | 1 | Bandwidth select write strobe |
| lpf_bw_wr | input | 2 | New low-pass bandwidth select |
| hpf_bw_wr | input | 2 | New high-pass bandwidth select |
| rd_addr | input | 2 | Monitor read address |
| lf_code | output | 3 | Low band equalizer code |
| hf_code | output | 3 | High band equalizer code |
| lf_conv | output | 1 | Low band convergence flag |
| hf_conv | output | 1 | High band convergence flag |
| lpf_bw | output | 2 | Low-pass bandwidth select |
| hpf_bw | output | 2 | High-pass bandwidth select |
| stage_ctrl | output | 24 | Control fields for the four equalizer stages |
| rd_data | output | 8 | Monitor read data |

## Verification
The bench sweeps thresholds 1 to 5 across every seed code with mixed vote patterns. Each strobe is compared with an arithmetic model. This catches a design that steps one vote early or late, or that lets a neutral vote break a run. It also catches a design that keeps counting after an opposite vote, or that wraps from 7 to 0 instead of clamping. Directed cases cover the following:
- A threshold of 0.
- Steps attempted at both limits.
- A freeze in the middle of a run, where a design that dropped or advanced the count would step at the wrong strobe.
- A seed load while frozen.
- Convergence windows with alternating votes, monotonic votes and `alt_m` = 0. A design that updated the flag at the wrong strobe, or counted a first step as a reversal, would show the wrong flag at a window boundary.

// File: rtl/eq_adapt_pkg.sv
package eq_adapt_pkg;

    typedef enum logic [1:0] {
        V_NONE = 2'd0,
        V_UP   = 2'd1,
        V_DN   = 2'd2
    } vote_e;

    typedef enum logic [1:0] {
        TRK_IDLE = 2'd0,
        TRK_UP   = 2'd1,
        TRK_DN   = 2'd2
    } trk_e;

    typedef enum logic [1:0] {
        RD_LF  = 2'd0,
        RD_HF  = 2'd1,
        RD_BW  = 2'd2,
        RD_NIL = 2'd3
    } rd_sel_e;

endpackage

// File: rtl/eq_window_timer.sv
module eq_window_timer #(
    parameter int WIN_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic load,
    output logic win_end
);
    localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [WIN_W-1:0] LAST = WIN_W'(WIN_LEN - 1);

    logic [WIN_W-1:0] wcnt;

    assign win_end = adv && (wcnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            wcnt <= '0;
        end else if (adv) begin
            wcnt <= win_end ? '0 : wcnt + WIN_W'(1);
        end
    end

    // R8: the window position never leaves its range
    p_win_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= LAST);

    // R6: the window does not advance without an enabled strobe
    p_win_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(wcnt));

endmodule

// File: rtl/eq_band_tracker.sv
module eq_band_tracker
    import eq_adapt_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int RUN_W  = 4,
    parameter int ALT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              load,
    input  logic              win_end,
    input  logic              up,
    input  logic              dn,
    input  logic [CODE_W-1:0] seed,
    input  logic [RUN_W-1:0]  agree_n,
    input  logic [ALT_W-1:0]  alt_m,
    output logic [CODE_W-1:0] code,
    output logic              conv
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [RUN_W-1:0]  RUN_ONE  = RUN_W'(1);

    vote_e             vote;
    trk_e              state, state_n;
    logic [RUN_W-1:0]  run_cnt, cnt_n, n_eff;
    logic [ALT_W-1:0]  alt_cnt, alt_n;
    logic              has_dir, last_up, hit, hit_n;
    logic              fire, fire_up;

    always_comb begin
        if (up && !dn)      vote = V_UP;
        else if (dn && !up) vote = V_DN;
        else                vote = V_NONE;
    end

    assign n_eff   = (agree_n == '0) ? RUN_ONE : agree_n;
    assign fire_up = (vote == V_UP);

    // next-state logic of the vote tracker
    always_comb begin
        state_n = state;
        cnt_n   = run_cnt;
        fire    = 1'b0;
        unique case (state)
            TRK_IDLE: begin
                if (vote == V_UP) begin
                    state_n = TRK_UP;
                    cnt_n   = RUN_ONE;
                end else if (vote == V_DN) begin
                    state_n = TRK_DN;
                    cnt_n   = RUN_ONE;
                end
            end
            TRK_UP: begin
                if (vote == V_UP) begin
                    cnt_n = run_cnt + RUN_ONE;
                end else if (vote == V_DN) begin
                    state_n = TRK_DN;
                    cnt_n   = RUN_ONE;
                end
            end
            TRK_DN: begin
                if (vote == V_DN) begin
                    cnt_n = run_cnt + RUN_ONE;
                end else if (vote == V_UP) begin
                    state_n = TRK_UP;
                    cnt_n   = RUN_ONE;
                end
            end
            default: state_n = TRK_IDLE;
        endcase
        if (vote != V_NONE && cnt_n >= n_eff) begin
            fire    = 1'b1;
            state_n = TRK_IDLE;
            cnt_n   = '0;
        end
        if (!adv) begin
            state_n = state;
            cnt_n   = run_cnt;
            fire    = 1'b0;
        end
    end

    always_comb begin
        alt_n = alt_cnt;
        if (fire && has_dir && (last_up != fire_up) && (alt_cnt != '1))
            alt_n = alt_cnt + ALT_W'(1);
        hit_n = hit || ((alt_m != '0) && (alt_n >= alt_m));
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            state   <= TRK_IDLE;
            run_cnt <= '0;
            has_dir <= 1'b0;
            last_up <= 1'b0;
            alt_cnt <= '0;
            hit     <= 1'b0;
        end else if (adv) begin
            state   <= state_n;
            run_cnt <= cnt_n;
            if (fire) begin
                has_dir <= 1'b1;
                last_up <= fire_up;
            end
            alt_cnt <= win_end ? '0 : alt_n;
            hit     <= win_end ? 1'b0 : hit_n;
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
            conv <= 1'b0;
        end else if (load) begin
            code <= seed;
            conv <= 1'b0;
        end else begin
            if (fire && fire_up && code != CODE_MAX)
                code <= code + CODE_W'(1);
            else if (fire && !fire_up && code != '0)
                code <= code - CODE_W'(1);
            if (win_end)
                conv <= hit_n;
        end
    end

    p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (code == $past(code))
              || ({1'b0, code} == {1'b0, $past(code)} + 1'b1)
              || ({1'b0, $past(code)} == {1'b0, code} + 1'b1));

    p_no_wrap_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && code == CODE_MAX) |=> code != '0);

    p_no_wrap_bot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && code == '0) |=> code != CODE_MAX);

    p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> ($stable(code) && $stable(conv)));

    p_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (code == $past(seed) && !conv));

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_end && !load) |=> $stable(conv));

    p_win_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |-> adv);

endmodule

// File: rtl/eq_reg_view.sv
module eq_reg_view
    import eq_adapt_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int BW_W   = 2,
    parameter int RD_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bw_wr,
    input  logic [BW_W-1:0]   lpf_bw_wr,
    input  logic [BW_W-1:0]   hpf_bw_wr,
    input  logic [1:0]        rd_addr,
    input  logic [CODE_W-1:0] lf_code,
    input  logic [CODE_W-1:0] hf_code,
    input  logic              lf_conv,
    input  logic              hf_conv,
    output logic [BW_W-1:0]   lpf_bw,
    output logic [BW_W-1:0]   hpf_bw,
    output logic [RD_W-1:0]   rd_data
);
    rd_sel_e sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lpf_bw <= '0;
            hpf_bw <= '0;
        end else if (bw_wr) begin
            lpf_bw <= lpf_bw_wr;
            hpf_bw <= hpf_bw_wr;
        end
    end

    assign sel = rd_sel_e'(rd_addr);

    always_comb begin
        unique case (sel)
            RD_LF:   rd_data = RD_W'({lf_conv, lf_code});
            RD_HF:   rd_data = RD_W'({hf_conv, hf_code});
            RD_BW:   rd_data = RD_W'({hpf_bw, lpf_bw});
            default: rd_data = '0;
        endcase
    end

    p_bw_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bw_wr |=> ($stable(lpf_bw) && $stable(hpf_bw)));

    p_bw_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bw_wr |=> (lpf_bw == $past(lpf_bw_wr) && hpf_bw == $past(hpf_bw_wr)));

endmodule

// File: rtl/eq_adapt_engine.sv
module eq_adapt_engine #(
    parameter int CODE_W     = 3,
    parameter int RUN_W      = 4,
    parameter int ALT_W      = 4,
    parameter int BW_W       = 2,
    parameter int WIN_LEN    = 16,
    parameter int NUM_STAGES = 4,
    parameter int RD_W       = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             adapt_en,
    input  logic                             vote_valid,
    input  logic                             lf_up,
    input  logic                             lf_dn,
    input  logic                             hf_up,
    input  logic                             hf_dn,
    input  logic                             seed_load,
    input  logic [CODE_W-1:0]                lf_seed,
    input  logic [CODE_W-1:0]                hf_seed,
    input  logic [RUN_W-1:0]                 agree_n,
    input  logic [ALT_W-1:0]                 alt_m,
    input  logic                             bw_wr,
    input  logic [BW_W-1:0]                  lpf_bw_wr,
    input  logic [BW_W-1:0]                  hpf_bw_wr,
    input  logic [1:0]                       rd_addr,
    output logic [CODE_W-1:0]                lf_code,
    output logic [CODE_W-1:0]                hf_code,
    output logic                             lf_conv,
    output logic                             hf_conv,
    output logic [BW_W-1:0]                  lpf_bw,
    output logic [BW_W-1:0]                  hpf_bw,
    output logic [NUM_STAGES*2*CODE_W-1:0]   stage_ctrl,
    output logic [RD_W-1:0]                  rd_data
);
    localparam int STG_W = 2 * CODE_W;

    logic adv, win_end;

    assign adv = vote_valid && adapt_en && !seed_load;

    eq_window_timer #(.WIN_LEN(WIN_LEN)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .load    (seed_load),
        .win_end (win_end)
    );

    eq_band_tracker #(.CODE_W(CODE_W), .RUN_W(RUN_W), .ALT_W(ALT_W)) u_lf (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .load    (seed_load),
        .win_end (win_end),
        .up      (lf_up),
        .dn      (lf_dn),
        .seed    (lf_seed),
        .agree_n (agree_n),
        .alt_m   (alt_m),
        .code    (lf_code),
        .conv    (lf_conv)
    );

    eq_band_tracker #(.CODE_W(CODE_W), .RUN_W(RUN_W), .ALT_W(ALT_W)) u_hf (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .load    (seed_load),
        .win_end (win_end),
        .up      (hf_up),
        .dn      (hf_dn),
        .seed    (hf_seed),
        .agree_n (agree_n),
        .alt_m   (alt_m),
        .code    (hf_code),
        .conv    (hf_conv)
    );

    eq_reg_view #(.CODE_W(CODE_W), .BW_W(BW_W), .RD_W(RD_W)) u_view (
        .clk       (clk),
        .rst_n     (rst_n),
        .bw_wr     (bw_wr),
        .lpf_bw_wr (lpf_bw_wr),
        .hpf_bw_wr (hpf_bw_wr),
        .rd_addr   (rd_addr),
        .lf_code   (lf_code),
        .hf_code   (hf_code),
        .lf_conv   (lf_conv),
        .hf_conv   (hf_conv),
        .lpf_bw    (lpf_bw),
        .hpf_bw    (hpf_bw),
        .rd_data   (rd_data)
    );

    for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
        assign stage_ctrl[gi*STG_W +: STG_W] = {hf_code, lf_code};
    end

    // R5: a seed load with equal seeds yields equal codes on the next edge
    p_seed_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && lf_seed == hf_seed) |=> (lf_code == hf_code));

endmodule

// File: tb/eq_adapt_engine_tb.sv
module eq_adapt_engine_tb;

    localparam int WIN = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adapt_en = 1'b1;
    logic       vote_valid = 1'b0;
    logic       lf_up = 1'b0, lf_dn = 1'b0, hf_up = 1'b0, hf_dn = 1'b0;
    logic       seed_load = 1'b0;
    logic [2:0] lf_seed = '0, hf_seed = '0;
    logic [3:0] agree_n = 4'd4;
    logic [3:0] alt_m = 4'd2;
    logic       bw_wr = 1'b0;
    logic [1:0] lpf_bw_wr = '0, hpf_bw_wr = '0;
    logic [1:0] rd_addr = '0;
    logic [2:0] lf_code, hf_code;
    logic       lf_conv, hf_conv;
    logic [1:0] lpf_bw, hpf_bw;
    logic [23:0] stage_ctrl;
    logic [7:0] rd_data;

    int checks = 0;
    int fails = 0;

    int m_code[2], m_cnt[2], m_run[2], m_hasdir[2], m_lastup[2];
    int m_alt[2], m_hit[2], m_conv[2];
    int m_wcnt = 0;
    int m_en = 1;

    eq_adapt_engine u_dut (
        .clk(clk), .rst_n(rst_n), .adapt_en(adapt_en), .vote_valid(vote_valid),
        .lf_up(lf_up), .lf_dn(lf_dn), .hf_up(hf_up), .hf_dn(hf_dn),
        .seed_load(seed_load), .lf_seed(lf_seed), .hf_seed(hf_seed),
        .agree_n(agree_n), .alt_m(alt_m), .bw_wr(bw_wr),
        .lpf_bw_wr(lpf_bw_wr), .hpf_bw_wr(hpf_bw_wr), .rd_addr(rd_addr),
        .lf_code(lf_code), .hf_code(hf_code), .lf_conv(lf_conv), .hf_conv(hf_conv),
        .lpf_bw(lpf_bw), .hpf_bw(hpf_bw), .stage_ctrl(stage_ctrl), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_band(int b, bit u, bit d, bit wend);
        int v, neff;
        v = (u && !d) ? 1 : ((d && !u) ? 2 : 0);
        neff = (agree_n == 0) ? 1 : int'(agree_n);
        if (v != 0) begin
            m_cnt[b] = (m_run[b] == v) ? m_cnt[b] + 1 : 1;
            m_run[b] = v;
            if (m_cnt[b] >= neff) begin
                if (v == 1 && m_code[b] < 7) m_code[b]++;
                if (v == 2 && m_code[b] > 0) m_code[b]--;
                if (m_hasdir[b] != 0 && m_lastup[b] != (v == 1 ? 1 : 0) && m_alt[b] < 15)
                    m_alt[b]++;
                m_hasdir[b] = 1;
                m_lastup[b] = (v == 1) ? 1 : 0;
                m_cnt[b] = 0;
                m_run[b] = 0;
            end
        end
        if (alt_m != 0 && m_alt[b] >= int'(alt_m)) m_hit[b] = 1;
        if (wend) begin
            m_conv[b] = m_hit[b];
            m_alt[b] = 0;
            m_hit[b] = 0;
        end
    endtask

    task automatic compare_all(string req);
        chk(req, "lf_code", int'(lf_code), m_code[0]);
        chk(req, "hf_code", int'(hf_code), m_code[1]);
        chk(req, "lf_conv", int'(lf_conv), m_conv[0]);
        chk(req, "hf_conv", int'(hf_conv), m_conv[1]);
        chk("R10", "rd lf", int'(rd_data), m_conv[0] * 8 + m_code[0]);
        chk("R11", "stage3", int'(stage_ctrl[23:18]), m_code[1] * 8 + m_code[0]);
    endtask

    // one decision strobe; checked at the following falling edge
    task automatic strobe(string req, bit lu, bit ld, bit hu, bit hd);
        bit wend;
        @(negedge clk);
        vote_valid = 1'b1;
        lf_up = lu; lf_dn = ld; hf_up = hu; hf_dn = hd;
        @(posedge clk);
        if (m_en != 0) begin
            wend = (m_wcnt == WIN - 1);
            m_wcnt = wend ? 0 : m_wcnt + 1;
            model_band(0, lu, ld, wend);
            model_band(1, hu, hd, wend);
        end
        @(negedge clk);
        vote_valid = 1'b0;
        lf_up = 0; lf_dn = 0; hf_up = 0; hf_dn = 0;
        #1;
        compare_all(req);
    endtask

    task automatic seed(int lf, int hf);
        @(negedge clk);
        seed_load = 1'b1;
        vote_valid = 1'b1;
        lf_up = 1'b1; hf_dn = 1'b1;
        lf_seed = 3'(lf); hf_seed = 3'(hf);
        @(negedge clk);
        seed_load = 1'b0;
        vote_valid = 1'b0;
        lf_up = 1'b0; hf_dn = 1'b0;
        for (int b = 0; b < 2; b++) begin
            m_cnt[b] = 0; m_run[b] = 0; m_hasdir[b] = 0; m_lastup[b] = 0;
            m_alt[b] = 0; m_hit[b] = 0; m_conv[b] = 0;
        end
        m_code[0] = lf; m_code[1] = hf;
        m_wcnt = 0;
        #1;
        compare_all("R7");
    endtask

    task automatic set_en(bit e);
        @(negedge clk);
        adapt_en = e;
        m_en = e ? 1 : 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: all requirements, actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        for (int b = 0; b < 2; b++) begin
            m_code[b] = 0; m_cnt[b] = 0; m_run[b] = 0; m_hasdir[b] = 0;
            m_lastup[b] = 0; m_alt[b] = 0; m_hit[b] = 0; m_conv[b] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        compare_all("R1");
        chk("R1", "lpf_bw", int'(lpf_bw), 0);
        chk("R1", "hpf_bw", int'(hpf_bw), 0);
        chk("R1", "stage bus", int'(stage_ctrl), 0);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #1;
            chk("R1", "rd_data", int'(rd_data), 0);
        end
        rd_addr = 2'd0;

        // R9 / R10 bandwidth selects and readback
        @(negedge clk);
        bw_wr = 1'b1; lpf_bw_wr = 2'd2; hpf_bw_wr = 2'd3;
        @(negedge clk);
        bw_wr = 1'b0; lpf_bw_wr = 2'd1; hpf_bw_wr = 2'd0;
        @(negedge clk);
        chk("R9", "lpf_bw", int'(lpf_bw), 2);
        chk("R9", "hpf_bw", int'(hpf_bw), 3);
        rd_addr = 2'd2; #1;
        chk("R10", "rd bw", int'(rd_data), 3 * 4 + 2);
        rd_addr = 2'd3; #1;
        chk("R10", "rd nil", int'(rd_data), 0);

        // R2 R3 R4 R5 sweep: thresholds 1..5, every seed, mixed votes
        for (int n = 1; n <= 5; n++) begin
            agree_n = 4'(n);
            for (int s = 0; s < 8; s++) begin
                seed(s, 7 - s);
                rd_addr = 2'd1; #1;
                chk("R10", "rd hf", int'(rd_data), m_conv[1] * 8 + m_code[1]);
                rd_addr = 2'd0;
                for (int k = 0; k < 12; k++) begin
                    int x, y;
                    x = (s * 7 + n * 3 + k * 5) % 6;
                    y = (s * 3 + k * 7 + n) % 5;
                    strobe("R2", x <= 2 || x == 4, x == 3 || x == 4,
                           y == 2 || y == 4, y <= 1 || y == 4);
                end
            end
        end

        // R3 opposite vote restarts the run
        agree_n = 4'd3;
        seed(4, 4);
        strobe("R3", 1, 0, 0, 1);
        strobe("R3", 1, 0, 0, 1);
        strobe("R3", 0, 1, 1, 0);
        strobe("R3", 0, 1, 1, 0);
        strobe("R3", 0, 1, 1, 0);
        chk("R3", "lf after reversal", int'(lf_code), 3);
        chk("R5", "hf after reversal", int'(hf_code), 5);

        // R2 threshold 0 acts as 1
        agree_n = 4'd0;
        seed(2, 2);
        strobe("R2", 1, 0, 1, 1);
        chk("R2", "lf n=0", int'(lf_code), 3);
        chk("R5", "hf neutral", int'(hf_code), 2);

        // R4 saturation at both limits
        agree_n = 4'd1;
        seed(7, 0);
        for (int k = 0; k < 3; k++) strobe("R4", 1, 0, 0, 1);
        chk("R4", "lf clamp high", int'(lf_code), 7);
        chk("R4", "hf clamp low", int'(hf_code), 0);
        strobe("R4", 0, 1, 1, 0);

        // R6 freeze mid-run keeps counts
        agree_n = 4'd2;
        seed(3, 3);
        strobe("R6", 1, 0, 0, 1);
        set_en(0);
        for (int k = 0; k < 3; k++) strobe("R6", 1, 0, 0, 1);
        chk("R6", "lf frozen", int'(lf_code), 3);
        set_en(1);
        strobe("R6", 1, 0, 0, 1);
        chk("R6", "lf resumes", int'(lf_code), 4);
        chk("R6", "hf resumes", int'(hf_code), 2);

        // R7 seed load while frozen
        set_en(0);
        seed(6, 1);
        set_en(1);

        // R8 convergence windows
        agree_n = 4'd1;
        alt_m = 4'd2;
        seed(3, 3);
        for (int k = 0; k < WIN; k++) strobe("R8", k % 2 == 0, k % 2 == 1, 1, 0);
        chk("R8", "lf conv alternating", int'(lf_conv), 1);
        chk("R8", "hf conv monotonic", int'(hf_conv), 0);
        for (int k = 0; k < WIN; k++) strobe("R8", 0, 0, 0, 0);
        chk("R8", "lf conv quiet window", int'(lf_conv), 0);
        alt_m = 4'd0;
        for (int k = 0; k < WIN; k++) strobe("R8", k % 2 == 0, k % 2 == 1, k % 2 == 1, k % 2 == 0);
        chk("R8", "lf conv m=0", int'(lf_conv), 0);
        alt_m = 4'd3;
        for (int k = 0; k < WIN + 3; k++) strobe("R8", k % 2 == 1, k % 2 == 0, k % 4 < 2, k % 4 >= 2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule